// File: doc/BRIEF.md
# Field-Programmable AND-OR Logic Array

This block is a register-configured sum-of-products logic array. A vector of input signals, each available in true and inverted form, feeds a bank of product terms, and each product term is formed by AND-ing whichever of those literals the configuration links in. A second programmable plane lets every output OR together any subset of the product terms, so one term can serve several outputs. Each OR result then passes through an XOR with a per-output polarity bit, which yields the true or the complemented function.

The configuration is held in flip-flops written through a plain address/data port, one register row per write. The evaluation path from `in_vec` to `out_vec` is purely combinational and uses the configuration currently held. By default the array has 16 inputs, 48 product terms and 8 outputs. The port and map widths follow from the parameters `N_IN`, `N_PT` and `N_OUT`.

The configuration port carries control, not a data stream, so it has no valid/ready handshake. A write with `cfg_we` high is always accepted at the next rising clock edge, and the block never applies back-pressure.

Top module: `pla_array`

## Requirements
- R1: After reset every link bit and every polarity bit is 0, so `out_vec` is all zeros for every input pattern.
- R2: A link bit of 0 (broken) in an AND row holds that AND input high. A row with no links therefore produces a product term of 1.
- R3: In AND row p, bit 2i links the true form of input i and bit 2i+1 links its inverted form. Product term p is the AND of all the literals that are linked.
- R4: In OR column k, bit p links product term p. Before polarity is applied, output k is the OR of the linked terms, and unlinked terms add nothing (they are held low).
- R5: A product term that links both the true and the inverted form of the same input is 0 for every input pattern.
- R6: One product term linked into several OR columns drives all of those outputs at once.
- R7: Polarity bit k set to 1 inverts output k, and set to 0 passes the OR result unchanged.
- R8: Address map. Addresses 0 to N_PT-1 hold the AND rows, in bits [2*N_IN-1:0]. Addresses N_PT to N_PT+N_OUT-1 hold the OR columns for outputs 0 upward, in bits [N_PT-1:0]. Address N_PT+N_OUT holds the polarity bits, in bits [N_OUT-1:0]. A write takes effect at the rising edge where `cfg_we` is high and does not show on `out_vec` before that edge.
- R9: A write to any address above N_PT+N_OUT changes no configuration and has no effect on `out_vec`.
- R10: `out_vec` follows `in_vec` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, clears all configuration |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration row address |
| cfg_wdata | input | DATA_W | Configuration row data |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
The bench uses a reduced array (4 inputs, 6 terms, 3 outputs) and sweeps every input pattern after each configuration change, so both literal polarities of every input are seen. Targeted corners:
- An empty AND row must give 1. A design that defaulted broken AND links low would leave such outputs stuck at 0.
- A row that links an input and its complement must give 0. Swapped literal bit order shows up as wrong minterms.
- A term shared by two outputs must reach both.
- Polarity must invert only its own output.
- Writes above the polarity address must leave every output untouched. A decoder that wrapped or aliased would corrupt a row.
- A write must show no effect until its clock edge.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    REG_AND  = 2'd0,
    REG_OR   = 2'd1,
    REG_POL  = 2'd2,
    REG_NONE = 2'd3
  } cfg_region_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic cfg_region_e decode_region(input int addr, input int npt, input int nout);
    if (addr < npt)             return REG_AND;
    else if (addr < npt + nout) return REG_OR;
    else if (addr == npt + nout) return REG_POL;
    else                         return REG_NONE;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_PT   = 48,
  parameter int N_OUT  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 48
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [N_PT-1:0][2*N_IN-1:0]       and_links,
  output logic [N_OUT-1:0][N_PT-1:0]        or_links,
  output logic [N_OUT-1:0]                  pol
);

  localparam int LIT_W    = 2 * N_IN;
  localparam int POL_ADDR = N_PT + N_OUT;

  cfg_region_e region;
  assign region = decode_region(int'(addr), N_PT, N_OUT);

  logic [N_PT-1:0][LIT_W-1:0] and_q;
  logic [N_OUT-1:0][N_PT-1:0] or_q;
  logic [N_OUT-1:0]           pol_q;

  for (genvar p = 0; p < N_PT; p++) begin : g_and_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        and_q[p] <= '0;
      else if (we && region == REG_AND && addr == ADDR_W'(p))
        and_q[p] <= wdata[LIT_W-1:0];
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_or_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        or_q[k] <= '0;
      else if (we && region == REG_OR && addr == ADDR_W'(N_PT + k))
        or_q[k] <= wdata[N_PT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pol_q <= '0;
    else if (we && region == REG_POL)
      pol_q <= wdata[N_OUT-1:0];
  end

  assign and_links = and_q;
  assign or_links  = or_q;
  assign pol       = pol_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (and_q == '0 && or_q == '0 && pol_q == '0)); // R1

  AST_POL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == POL_ADDR) |=> (pol_q == $past(wdata[N_OUT-1:0]))); // R8

  AST_UNMAPPED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) > POL_ADDR) |=> ($stable(and_q) && $stable(or_q) && $stable(pol_q))); // R9

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN = 16,
  parameter int N_PT = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             in_vec,
  input  logic [N_PT-1:0][2*N_IN-1:0] and_links,
  output logic [N_PT-1:0]             terms
);

  localparam int LIT_W = 2 * N_IN;

  logic [LIT_W-1:0] literals;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      literals[2*i]   = in_vec[i];
      literals[2*i+1] = ~in_vec[i];
    end
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    // broken link forces that AND input high
    assign terms[p] = &(literals | ~and_links[p]);

    logic clash;
    always_comb begin
      clash = 1'b0;
      for (int i = 0; i < N_IN; i++)
        clash = clash | (and_links[p][2*i] & and_links[p][2*i+1]);
    end

    AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> !terms[p]); // R5

    AST_EMPTY_ROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (and_links[p] == '0) |-> terms[p]); // R2
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT  = 48,
  parameter int N_OUT = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PT-1:0]             terms,
  input  logic [N_OUT-1:0][N_PT-1:0]  or_links,
  input  logic [N_OUT-1:0]            pol,
  output logic [N_OUT-1:0]            out_vec
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic sum;
    // broken link forces that OR input low
    assign sum        = |(terms & or_links[k]);
    assign out_vec[k] = sum ^ pol[k];

    AST_UNLINKED_FOLLOWS_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (or_links[k] == '0) |-> (out_vec[k] == pol[k])); // R4
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_PT   = 48,
  parameter int N_OUT  = 8,
  parameter int ADDR_W = $clog2(N_PT + N_OUT + 1),
  parameter int DATA_W = max3(2 * N_IN, N_PT, N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);

  localparam int LIT_W = 2 * N_IN;

  logic [N_PT-1:0][LIT_W-1:0] and_links;
  logic [N_OUT-1:0][N_PT-1:0] or_links;
  logic [N_OUT-1:0]           pol;
  logic [N_PT-1:0]            terms;

  pla_cfg_store #(
    .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .and_links (and_links),
    .or_links  (or_links),
    .pol       (pol)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vec    (in_vec),
    .and_links (and_links),
    .terms     (terms)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .clk      (clk),
    .rst_n    (rst_n),
    .terms    (terms),
    .or_links (or_links),
    .pol      (pol),
    .out_vec  (out_vec)
  );

endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NP = 6;
  localparam int NO = 3;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int POL_A = NP + NO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] out_vec;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [NP-1:0][2*NI-1:0] m_and;
  logic [NO-1:0][NP-1:0]   m_or;
  logic [NO-1:0]           m_pol;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array #(.N_IN(NI), .N_PT(NP), .N_OUT(NO), .ADDR_W(AW), .DATA_W(DW)) u_pla_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_vec(in_vec), .out_vec(out_vec)
  );

  function automatic logic [NO-1:0] expect_out(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    logic [NP-1:0] pt;
    for (int p = 0; p < NP; p++) begin
      pt[p] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (m_and[p][2*i]   && !x[i]) pt[p] = 1'b0;
        if (m_and[p][2*i+1] &&  x[i]) pt[p] = 1'b0;
      end
    end
    for (int k = 0; k < NO; k++)
      r[k] = ((pt & m_or[k]) != '0) ^ m_pol[k];
    return r;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NP)          m_and[a] = d[2*NI-1:0];
    else if (a < POL_A)  m_or[a-NP] = d[NP-1:0];
    else if (a == POL_A) m_pol = d[NO-1:0];
  endtask

  task automatic check(input string tag, input logic [NO-1:0] exp);
    n_vec++;
    if (out_vec !== exp) begin
      n_fail++;
      $display("FAIL %s in=%h out=%b exp=%b", tag, in_vec, out_vec, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << NI); v++) begin
      in_vec = NI'(v);
      #1;
      check(tag, expect_out(NI'(v)));
    end
  endtask

  task automatic clear_all();
    for (int a = 0; a <= POL_A; a++) wr(a, '0);
  endtask

  initial begin
    m_and = '0; m_or = '0; m_pol = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, all outputs low for all inputs
    for (int v = 0; v < (1 << NI); v++) begin
      in_vec = NI'(v); #1;
      check("R1 reset", '0);
    end

    // R2: empty AND rows give 1; link term 0 to every output
    for (int k = 0; k < NO; k++) wr(NP + k, 8'h01);
    sweep("R2 empty row");

    // R3: literal encoding; out0 = in0 & ~in1, out1 = ~in3, out2 = in2
    clear_all();
    wr(0, 8'b0000_1001);
    wr(1, 8'b1000_0000);
    wr(2, 8'b0001_0000);
    wr(NP + 0, 8'b000001);
    wr(NP + 1, 8'b000010);
    wr(NP + 2, 8'b000100);
    sweep("R3 literals");
    for (int v = 0; v < 16; v++) begin
      in_vec = NI'(v); #1;
      check("R3 direct", {v[2], ~v[3], v[0] & ~v[1]});
    end

    // R4: sum of several terms in one output
    wr(NP + 0, 8'b000111);
    sweep("R4 or sum");

    // R5: conflicting literals in term 3
    wr(3, 8'b0000_1100);
    wr(NP + 1, 8'b001000);
    sweep("R5 conflict");
    for (int v = 0; v < 16; v++) begin
      in_vec = NI'(v); #1;
      check("R5 direct", {out_vec[2], 1'b0, out_vec[0]});
    end

    // R6: term 4 (in1 & in2) shared by outputs 1 and 2
    wr(4, 8'b0001_0100);
    wr(NP + 1, 8'b010000);
    wr(NP + 2, 8'b010000);
    sweep("R6 shared");

    // R7: polarity per output
    wr(POL_A, 8'b0000_0101);
    sweep("R7 polarity");
    wr(POL_A, 8'b0000_0010);
    sweep("R7 polarity b");

    // R8: write not visible before its edge
    in_vec = 4'h6;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(POL_A); cfg_wdata = 8'h07;
    #1;
    check("R8 before edge", expect_out(4'h6));
    @(negedge clk);
    cfg_we = 1'b0;
    m_pol = 3'b111;
    #1;
    check("R8 after edge", expect_out(4'h6));

    // R9: unmapped addresses ignored
    for (int a = POL_A + 1; a < (1 << AW); a++) wr(a, 8'hFF);
    sweep("R9 unmapped");

    // R10/R8: pseudo-random full configurations
    for (int c = 0; c < 12; c++) begin
      for (int a = 0; a <= POL_A; a++) wr(a, DW'($urandom));
      sweep("R10 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule